// File: doc/BRIEF.md
# Shared Timer and Watchdog Prescaler

This block holds an 8-bit timer/counter and an 8-bit watchdog counter that share a single 8-bit prescaler. A write-only 6-bit mode register controls four things. It picks the timer's count source, which is either the instruction-cycle enable or an external pin. It sets which pin edge is counted. It decides whether the prescaler sits in front of the timer or behind the watchdog. It also sets the division ratio. The external pin passes through a two-stage synchronizer followed by an edge detector before it can count.

The watchdog advances on a tick enable that comes from a separate slow oscillator. That tick is modelled as a clock enable in the single clock domain. The watchdog runs only while its hardware enable is high, and it keeps running during sleep. The clear-watchdog and sleep strobes reset the watchdog counter. Software can load the timer at any time. The block signals a timer wrap and a watchdog wrap with one-cycle pulses.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the timer reads 00h, both pulse outputs are low, and the mode register holds 3Fh. In that state the external pin is the source, the falling edge is counted, the prescaler is assigned to the watchdog and the ratio code is 7. While the pin is selected, cyc_en pulses do not move the timer.
- R2: The mode register fields are: bits [2:0] ratio code, bit 3 prescaler assignment (1 = watchdog, 0 = timer), bit 4 edge select (1 = falling, 0 = rising), bit 5 timer source (1 = external pin, 0 = cyc_en). A write on sel_we takes effect from the next cycle.
- R3: With the internal source selected and the prescaler on the watchdog, the timer rises by exactly one for each cycle in which cyc_en is high, and holds otherwise.
- R4: With the prescaler on the timer, ratio code k gives one timer increment per 2^(k+1) source events, counted from the last prescaler clear.
- R5: With the external source selected, the timer counts only the chosen edge of ext_pin after synchronization. A level held for at least two cycles is always counted, and cyc_en is ignored.
- R6: A timer write loads tmr_wdata in the next cycle and takes priority over an increment in the same cycle. While the prescaler is on the timer, the write also clears the prescaler.
- R7: When an increment takes the timer from FFh to 00h, tmr_ovf is high for exactly the one cycle in which the timer first reads 00h. A load never raises it.
- R8: The watchdog advances only on wd_tick while wd_hw_en is high. With the prescaler on the watchdog, ratio code k gives one advance per 2^k ticks. With the prescaler on the timer, it advances on every tick.
- R9: wd_timeout pulses for one cycle when the watchdog counter wraps from FFh to 00h. It never pulses while wd_hw_en is low.
- R10: wd_clear and sleep_req each clear the watchdog counter. They also clear the prescaler only while it is assigned to the watchdog; while it is assigned to the timer they leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | External count input (asynchronous) |
| wd_tick | input | 1 | Watchdog oscillator tick enable |
| wd_hw_en | input | 1 | Watchdog hardware enable |
| sel_we | input | 1 | Mode register write strobe |
| sel_wdata | input | 6 | Mode register write data |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wd_clear | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep strobe |
| tmr_value | output | 8 | Current timer value |
| tmr_ovf | output | 1 | Timer wrap pulse |
| wd_timeout | output | 1 | Watchdog wrap pulse |

## Verification
The assertions check the local rules on every cycle:
- a load appears one cycle after the write;
- an overflow pulse coincides with a zero timer and never lasts two cycles;
- a clear empties the prescaler and the watchdog counter;
- a disabled watchdog never times out;
- an idle internal source leaves the timer still.

Only the bench scenarios can show the rest: the division ratios, which edge polarity is counted, and the exact tick on which a timeout arrives. The same holds for whether a clear reached the prescaler. That can only be seen as a one-tick shift in timeout timing or as a change in the timer count.

// File: rtl/spt_pkg.sv
package spt_pkg;
    localparam int PSC_W   = 8;
    localparam int RATIO_W = 3;
    localparam int CNT_W   = 8;
    localparam int SEL_W   = 6;
    localparam int SYNC_N  = 2;

    typedef struct packed {
        logic               ext_src;
        logic               fall_edge;
        logic               psc_to_wd;
        logic [RATIO_W-1:0] ratio;
    } sel_t;

    localparam logic [SEL_W-1:0] SEL_RESET = 6'h3F;

    // Low bits of the prescaler that must all be ones for a tap:
    // timer side divides by 2^(r+1), watchdog side by 2^r.
    function automatic logic [PSC_W-1:0] tap_mask(input logic [RATIO_W-1:0] r,
                                                  input logic to_wd);
        logic [PSC_W:0] span;
        span = {{PSC_W{1'b0}}, 1'b1} << r;
        if (!to_wd) span = span << 1;
        return PSC_W'(span - 1'b1);
    endfunction
endpackage

// File: rtl/spt_ext_sync.sv
module spt_ext_sync #(
    parameter int STAGES = spt_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES:0] chain;
    logic            cur, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= pin;
            for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign cur  = chain[STAGES-1];
    assign prev = chain[STAGES];

    always_comb begin
        if (fall_sel) edge_pulse = prev & ~cur;
        else          edge_pulse = cur & ~prev;
    end

    // R5: a pulse marks a real change of the synchronized level
    AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |-> (cur != prev)); // R5
endmodule

// File: rtl/spt_prescaler.sv
module spt_prescaler
    import spt_pkg::*;
#(
    parameter int W  = PSC_W,
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    input  logic [RW-1:0] ratio,
    input  logic          to_wd,
    output logic          tap
);
    logic [W-1:0] cnt;
    logic [W-1:0] mask;

    assign mask = W'(tap_mask(RATIO_W'(ratio), to_wd));
    assign tap  = inc && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R10
    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt)); // R4
endmodule

// File: rtl/spt_timer.sv
module spt_timer #(
    parameter int W = spt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         ovf
);
    logic [W:0] nxt;
    assign nxt = {1'b0, value} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (we) begin
                value <= wdata;
            end else if (step) begin
                value <= nxt[W-1:0];
                ovf   <= nxt[W];
            end
        end
    end

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> (value == $past(wdata))); // R6
    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (value == '0)); // R7
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf); // R7
endmodule

// File: rtl/spt_watchdog.sv
module spt_watchdog #(
    parameter int W = spt_pkg::CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic step,
    input  logic clr,
    output logic timeout
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (en && step) begin
                cnt     <= cnt + 1'b1;
                timeout <= (cnt == '1);
            end
        end
    end

    AST_WD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !timeout); // R9
    AST_WD_WRAP: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (cnt == '0)); // R9
    AST_WD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !timeout)); // R10
    AST_WD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt)); // R8
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
    import spt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             wd_tick,
    input  logic             wd_hw_en,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             tmr_we,
    input  logic [CNT_W-1:0] tmr_wdata,
    input  logic             wd_clear,
    input  logic             sleep_req,
    output logic [CNT_W-1:0] tmr_value,
    output logic             tmr_ovf,
    output logic             wd_timeout
);
    sel_t sel;
    logic ext_edge, src_evt, wd_clr;
    logic psc_inc, psc_clr, psc_tap;
    logic tmr_step, wd_step;

    always_ff @(posedge clk) begin
        if (rst)         sel <= sel_t'(SEL_RESET);
        else if (sel_we) sel <= sel_t'(sel_wdata);
    end

    spt_ext_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .fall_sel(sel.fall_edge), .edge_pulse(ext_edge)
    );

    assign src_evt = sel.ext_src ? ext_edge : cyc_en;
    assign wd_clr  = wd_clear | sleep_req;

    // Prescaler routing: one bit swaps its input, clear and output users.
    always_comb begin
        if (sel.psc_to_wd) begin
            psc_inc  = wd_tick & wd_hw_en;
            psc_clr  = wd_clr;
            tmr_step = src_evt;
            wd_step  = psc_tap;
        end else begin
            psc_inc  = src_evt;
            psc_clr  = tmr_we;
            tmr_step = psc_tap;
            wd_step  = wd_tick;
        end
    end

    spt_prescaler #(.W(PSC_W), .RW(RATIO_W)) u_psc (
        .clk(clk), .rst(rst), .inc(psc_inc), .clr(psc_clr),
        .ratio(sel.ratio), .to_wd(sel.psc_to_wd), .tap(psc_tap)
    );

    spt_timer #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .step(tmr_step), .we(tmr_we),
        .wdata(tmr_wdata), .value(tmr_value), .ovf(tmr_ovf)
    );

    spt_watchdog #(.W(CNT_W)) u_wd (
        .clk(clk), .rst(rst), .en(wd_hw_en), .step(wd_step),
        .clr(wd_clr), .timeout(wd_timeout)
    );

    AST_SEL_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel == sel_t'(SEL_RESET))); // R1
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (sel == sel_t'($past(sel_wdata)))); // R2
    AST_INT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sel.ext_src && sel.psc_to_wd && !cyc_en && !tmr_we) |=> $stable(tmr_value)); // R3
endmodule

// File: tb/sim_shared_prescale_timer.sv
`timescale 1ns/1ps
module sim_shared_prescale_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 0, ext_pin = 0, wd_tick = 0, wd_hw_en = 0;
    logic       sel_we = 0, tmr_we = 0, wd_clear = 0, sleep_req = 0;
    logic [5:0] sel_wdata = '0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr_value;
    logic       tmr_ovf, wd_timeout;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shared_prescale_timer u0 (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wd_tick(wd_tick), .wd_hw_en(wd_hw_en), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .wd_clear(wd_clear), .sleep_req(sleep_req), .tmr_value(tmr_value),
        .tmr_ovf(tmr_ovf), .wd_timeout(wd_timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected timer after n source events from a load of w (R3, R4)
    function automatic int exp_timer(int w, int n, int k, bit to_wd);
        if (to_wd) return (w + n) % 256;
        return (w + (n >> (k + 1))) % 256;
    endfunction

    task automatic wr_sel(input logic [5:0] v);
        @(negedge clk); sel_we = 1; sel_wdata = v;
        @(negedge clk); sel_we = 0;
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        @(negedge clk); tmr_we = 1; tmr_wdata = v;
        @(negedge clk); tmr_we = 0;
    endtask

    task automatic cyc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cyc_en = 1;
            @(negedge clk); cyc_en = 0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic pin_level(input logic lvl, input int hold);
        @(negedge clk); ext_pin = lvl;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic strobe_clear(input bit use_sleep);
        @(negedge clk);
        if (use_sleep) sleep_req = 1; else wd_clear = 1;
        @(negedge clk); sleep_req = 0; wd_clear = 0;
    endtask

    task automatic wd_ticks(input int n, output int hits, output int first);
        hits = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); wd_tick = 1;
            @(negedge clk); wd_tick = 0;
            if (wd_timeout) begin
                hits++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin : watchdog_timer
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog run timed out actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        int hits, first;
        void'($urandom(32'h5eed_0101));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 timer reset", tmr_value, 0);
        check("R1 ovf reset", tmr_ovf, 0);
        check("R1 timeout reset", wd_timeout, 0);

        // R1 default mode: external source, so cyc_en is ignored
        cyc_pulses(5);
        check("R1 cyc ignored under default source", tmr_value, 0);
        // R1 default falling edge, prescaler on watchdog: rising alone does nothing
        pin_level(1, 3); repeat (4) @(negedge clk);
        check("R1 rising edge not counted by default", tmr_value, 0);
        pin_level(0, 3); repeat (4) @(negedge clk);
        check("R1 falling edge counted by default", tmr_value, 1);

        // R2 R3: code 08h = internal source, prescaler on watchdog, ratio 0
        wr_sel(6'h08); wr_tmr(8'h10);
        cyc_pulses(7);
        check("R3 internal count", tmr_value, 8'h17);

        // R5: code 28h = external rising, prescaler on watchdog
        wr_sel(6'h28); wr_tmr(8'h00);
        for (int i = 0; i < 3; i++) begin pin_level(1, 2); pin_level(0, 2); end
        repeat (4) @(negedge clk);
        check("R5 rising edges with 2-cycle levels", tmr_value, 3);
        cyc_pulses(4);
        check("R5 cyc ignored on external source", tmr_value, 3);

        // R4 random ratios and assignments, internal source
        for (int it = 0; it < 40; it++) begin
            int k, n, w; bit tw;
            k  = $urandom_range(0, 7);
            tw = $urandom_range(0, 1);
            n  = $urandom_range(0, 300);
            w  = $urandom_range(0, 255);
            wr_sel({2'b00, tw, 3'(k)});
            wr_tmr(8'(w));
            cyc_pulses(n);
            check($sformatf("R4 ratio k=%0d to_wd=%0d n=%0d", k, tw, n),
                  tmr_value, exp_timer(w, n, k, tw));
        end

        // R6: prescaler on timer, ratio 1 (divide by 4); write clears it
        wr_sel(6'h01); wr_tmr(8'h00);
        cyc_pulses(3);
        wr_tmr(8'h40);
        cyc_pulses(3);
        check("R6 write clears prescaler", tmr_value, 8'h40);
        cyc_pulses(1);
        check("R6 count after cleared prescaler", tmr_value, 8'h41);
        wr_sel(6'h08);
        @(negedge clk); tmr_we = 1; tmr_wdata = 8'h55; cyc_en = 1;
        @(negedge clk); tmr_we = 0; cyc_en = 0;
        check("R6 write beats increment", tmr_value, 8'h55);

        // R7 overflow pulse
        wr_tmr(8'hFE);
        @(negedge clk); cyc_en = 1; @(negedge clk); cyc_en = 0;
        check("R7 no ovf at FF", tmr_ovf, 0);
        @(negedge clk); cyc_en = 1; @(negedge clk); cyc_en = 0;
        check("R7 ovf with 00", tmr_ovf, 1);
        check("R7 value 00 on wrap", tmr_value, 0);
        @(negedge clk);
        check("R7 ovf one cycle", tmr_ovf, 0);
        wr_tmr(8'hFF); wr_tmr(8'h00);
        check("R7 load gives no ovf", tmr_ovf, 0);

        // R8 R9 watchdog timing
        wd_hw_en = 1;
        wr_sel(6'h08); strobe_clear(0);
        wd_ticks(256, hits, first);
        check("R9 ratio0 timeout count", hits, 1);
        check("R8 ratio0 timeout tick", first, 256);
        wr_sel(6'h0A); strobe_clear(0);
        wd_ticks(1024, hits, first);
        check("R8 ratio2 timeout tick", first, 1024);
        wr_sel(6'h07); strobe_clear(0);
        wd_ticks(256, hits, first);
        check("R8 prescaler on timer, every tick", first, 256);

        wd_hw_en = 0; wr_sel(6'h08); strobe_clear(0);
        wd_ticks(600, hits, first);
        check("R9 disabled no timeout", hits, 0);
        wd_hw_en = 1; strobe_clear(0);
        wd_ticks(256, hits, first);
        check("R9 re-enabled timeout tick", first, 256);

        // R10: clear also empties prescaler when on watchdog (ratio 1)
        wr_sel(6'h09); strobe_clear(0);
        wd_ticks(3, hits, first);
        strobe_clear(0);
        wd_ticks(512, hits, first);
        check("R10 clear resets prescaler and counter", first, 512);
        strobe_clear(0);
        wd_ticks(3, hits, first);
        strobe_clear(1);
        wd_ticks(512, hits, first);
        check("R10 sleep acts as clear", first, 512);

        // R10: prescaler on timer is not touched by wd_clear
        wd_hw_en = 0;
        wr_sel(6'h01); wr_tmr(8'h00);
        cyc_pulses(2);
        strobe_clear(0);
        cyc_pulses(2);
        check("R10 clear leaves timer prescaler", tmr_value, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule